// File: doc/BRIEF.md
# Symmetric Complementary PWM Channel with Dead Band

This block drives one half-bridge leg from a single PWM channel. It makes a pair of active-low gate commands, `hs_n` for the upper switch and `ls_n` for the lower one. A low level on either pin turns its switch on. Each switching period is built from two equal halves. A triangle timer counts up through the first half and back down through the second, so both gate waveforms are mirror images about the turnaround point in the middle of the period.

Three values set the waveform: the span (the half-period length), a signed duty offset measured from the middle of the timer range, and a dead-band width. The block copies all three into shadow storage only when a new period begins, so a change never affects a period that is already running. From the shadow copies it places the upper switch's edges and the lower switch's edges. Each edge is pulled back from the ideal crossing point by the dead-band width, which leaves a guard interval between the two on-intervals. A one-cycle sync pulse marks the first tick of every period, and a phase flag shows which half is running.

Top module: `cpwm_halfbridge`

## Requirements
- R1: While reset is asserted, and from the cycle after `enable` is sampled low, both `hs_n` and `ls_n` are 1 (both switches off), and `sync` and `phase` are 0.
- R2: The effective span P is the `period` input with bit 0 cleared, and any value below 2 is raised to 2. One full period lasts 2·P clock cycles. `sync` is 1 for exactly the first cycle of each period, so consecutive `sync` pulses are 2·P cycles apart.
- R3: `phase` is 0 for the first P cycles of a period and 1 for the last P cycles.
- R4: `duty` is a two's-complement value. Per period, `hs_n` is low for exactly clamp(P + 2·(duty − dead), 0, 2·P) cycles, where `dead` is an unsigned cycle count.
- R5: Per period, `ls_n` is low for exactly clamp(P − 2·(duty + dead), 0, 2·P) cycles.
- R6: Both outputs are mirror-symmetric within a period: the value at cycle i equals the value at cycle 2·P−1−i.
- R7: `hs_n` and `ls_n` are never low in the same cycle.
- R8: `period`, `duty` and `dead` are captured only in the cycle just before the first cycle of a period. A change made during a period does not alter that period and takes effect in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the channel when 1; forces both switches off when 0 |
| period | input | CNT_W | Requested half-period span in cycles (bit 0 ignored, minimum 2) |
| duty | input | CNT_W+1 | Signed duty offset from mid-range |
| dead | input | DT_W | Dead-band width in cycles |
| hs_n | output | 1 | Upper switch command, low = on |
| ls_n | output | 1 | Lower switch command, low = on |
| sync | output | 1 | One-cycle pulse on the first cycle of each period |
| phase | output | 1 | 0 in the first half, 1 in the second half |

## Verification
The bench sweeps duty past both saturation points for several small spans and dead-band widths. A design with an off-by-one edge compare, or with clamping that wraps around, would report on-time counts that drift from the closed-form values at the ends of the range. Odd and too-small `period` values test the span rule, and the sync spacing would expose a timer that repeats or skips its turnaround tick. A duty change made part-way through a period checks that the running period keeps its old waveform. Dropping the enable while the lower switch is on checks that the outputs go off in the very next cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    HALF_RISE = 1'b0,
    HALF_FALL = 1'b1
  } half_e;

  // Effective span: bit 0 dropped, floor of 2.
  function automatic int eff_span(input int raw);
    int p;
    p = raw & ~1;
    return (p < 2) ? 2 : p;
  endfunction

  // Lowest timer value at which the upper switch is on.
  function automatic int hs_on_from(input int span, input int duty, input int dt);
    return span / 2 - duty + dt;
  endfunction

  // Timer values below this turn the lower switch on.
  function automatic int ls_on_below(input int span, input int duty, input int dt);
    return span / 2 - duty - dt;
  endfunction

endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CNT_W-1:0]        period_in,
  input  logic signed [CNT_W:0]   duty_in,
  input  logic [DT_W-1:0]         dead_in,
  output logic [CNT_W-1:0]        span_q,
  output logic signed [CNT_W:0]   duty_q,
  output logic [DT_W-1:0]         dead_q
);
  import cpwm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= CNT_W'(2);
      duty_q <= '0;
      dead_q <= '0;
    end else if (load) begin
      span_q <= CNT_W'(eff_span(int'(period_in)));
      duty_q <= duty_in;
      dead_q <= dead_in;
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(span_q) && $stable(duty_q) && $stable(dead_q)));

  // R2
  span_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (span_q[0] == 1'b0) && (span_q >= CNT_W'(2)));

endmodule

// File: rtl/cpwm_tri_timer.sv
module cpwm_tri_timer #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  span,
  output logic [CNT_W-1:0]  cnt,
  output cpwm_pkg::half_e   half,
  output logic              run,
  output logic              start,
  output logic              sync
);
  import cpwm_pkg::*;

  logic last_tick;
  logic at_top;

  assign last_tick = run && (half == HALF_FALL) && (cnt == '0);
  assign at_top    = (cnt == span - CNT_W'(1));
  assign start     = enable && (!run || last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      half <= HALF_RISE;
      sync <= 1'b0;
    end else if (!enable) begin
      run  <= 1'b0;
      cnt  <= '0;
      half <= HALF_RISE;
      sync <= 1'b0;
    end else if (start) begin
      run  <= 1'b1;
      cnt  <= '0;
      half <= HALF_RISE;
      sync <= 1'b1;
    end else begin
      sync <= 1'b0;
      if (half == HALF_RISE) begin
        if (at_top) half <= HALF_FALL;
        else        cnt  <= cnt + CNT_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R2
  sync_first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (run && cnt == '0 && half == HALF_RISE));

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < span));

  // R3
  turn_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(half)) |-> (cnt == $past(cnt)));

endmodule

// File: rtl/cpwm_edge.sv
module cpwm_edge #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        span,
  input  logic signed [CNT_W:0]   duty,
  input  logic [DT_W-1:0]         dead,
  output logic                    hs_n,
  output logic                    ls_n
);
  import cpwm_pkg::*;

  int   hs_from;
  int   ls_below;
  logic hs_on;
  logic ls_on;

  assign hs_from  = hs_on_from(int'(span), int'(duty), int'(dead));
  assign ls_below = ls_on_below(int'(span), int'(duty), int'(dead));

  // Signed compares saturate on their own: a threshold outside 0..span
  // gives a switch that is on or off for the whole period.
  assign hs_on = run && (int'(cnt) >= hs_from);
  assign ls_on = run && (int'(cnt) <  ls_below);

  assign hs_n = ~hs_on;
  assign ls_n = ~ls_on;

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

endmodule

// File: rtl/cpwm_halfbridge.sv
module cpwm_halfbridge #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [CNT_W-1:0]       period,
  input  logic signed [CNT_W:0]  duty,
  input  logic [DT_W-1:0]        dead,
  output logic                   hs_n,
  output logic                   ls_n,
  output logic                   sync,
  output logic                   phase
);
  import cpwm_pkg::*;

  logic [CNT_W-1:0]       span_q;
  logic signed [CNT_W:0]  duty_q;
  logic [DT_W-1:0]        dead_q;
  logic [CNT_W-1:0]       cnt;
  half_e                  half;
  logic                   run;
  logic                   period_start;

  cpwm_shadow #(.CNT_W(CNT_W), .DT_W(DT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(period_start),
    .period_in(period), .duty_in(duty), .dead_in(dead),
    .span_q(span_q), .duty_q(duty_q), .dead_q(dead_q)
  );

  cpwm_tri_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .span(span_q),
    .cnt(cnt), .half(half), .run(run), .start(period_start), .sync(sync)
  );

  cpwm_edge #(.CNT_W(CNT_W), .DT_W(DT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
    .span(span_q), .duty(duty_q), .dead(dead_q),
    .hs_n(hs_n), .ls_n(ls_n)
  );

  assign phase = run && (half == HALF_FALL);

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hs_n && ls_n && !sync && !phase));

  // R3
  phase_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !phase);

endmodule

// File: tb/cpwm_halfbridge_tb.sv
`timescale 1ns/1ps
module cpwm_halfbridge_tb;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic signed [CNT_W:0] duty = '0;
  logic [DT_W-1:0] dead = '0;
  logic hs_n, ls_n, sync, phase;

  int errs = 0;
  int checks = 0;

  bit hsv [0:63];
  bit lsv [0:63];
  bit phv [0:63];
  bit syv [0:63];

  always #2.5 clk = ~clk;

  cpwm_halfbridge #(.CNT_W(CNT_W), .DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .duty(duty), .dead(dead), .hs_n(hs_n), .ls_n(ls_n),
    .sync(sync), .phase(phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic wait_sync();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sync && guard < 1000);
    chk(sync == 1'b1, "R2 sync seen", int'(sync), 1);
  endtask

  // Apply a configuration at a period start, then record the next full period.
  task automatic measure(input int praw, input int d, input int t,
                         input bit mid_change, input int d2);
    int p, eh, el, nh, nl, asym, ovl, pherr, syerr;
    p = praw & ~1;
    if (p < 2) p = 2;
    wait_sync();
    period = CNT_W'(praw);
    duty   = (CNT_W+1)'(d);
    dead   = DT_W'(t);
    wait_sync();
    for (int i = 0; i < 2*p; i++) begin
      if (i > 0) @(negedge clk);
      hsv[i] = hs_n; lsv[i] = ls_n; phv[i] = phase; syv[i] = sync;
      if (mid_change && i == 1) duty = (CNT_W+1)'(d2);
    end
    @(negedge clk);
    chk(sync == 1'b1, "R2 period length", int'(sync), 1);
    nh = 0; nl = 0; asym = 0; ovl = 0; pherr = 0; syerr = 0;
    for (int i = 0; i < 2*p; i++) begin
      if (!hsv[i]) nh++;
      if (!lsv[i]) nl++;
      if (hsv[i] != hsv[2*p-1-i] || lsv[i] != lsv[2*p-1-i]) asym++;
      if (!hsv[i] && !lsv[i]) ovl++;
      if (phv[i] != (i >= p)) pherr++;
      if (syv[i] != (i == 0)) syerr++;
    end
    eh = clampi(p + 2*(d - t), 2*p);
    el = clampi(p - 2*(d + t), 2*p);
    chk(nh == eh, "R4 high-side on cycles", nh, eh);
    chk(nl == el, "R5 low-side on cycles", nl, el);
    chk(asym == 0, "R6 mirror mismatches", asym, 0);
    chk(ovl == 0, "R7 overlap cycles", ovl, 0);
    chk(pherr == 0, "R3 phase mismatches", pherr, 0);
    chk(syerr == 0, "R2 sync placement", syerr, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int plist [6] = '{0, 3, 4, 6, 7, 8};
    int tlist [3] = '{0, 1, 3};
    enable = 1'b1;
    period = CNT_W'(8);
    repeat (3) @(negedge clk);
    // R1: reset holds switches off even with enable high
    chk(hs_n && ls_n && !sync && !phase, "R1 reset state",
        {hs_n, ls_n, sync, phase}, 4'b1100);
    rst_n = 1'b1;

    foreach (plist[pi]) begin
      int p;
      p = plist[pi] & ~1;
      if (p < 2) p = 2;
      foreach (tlist[ti]) begin
        for (int d = -(p/2) - 3; d <= p/2 + 3; d++)
          measure(plist[pi], d, tlist[ti], 1'b0, 0);
      end
    end

    // Wide dead band swallows both on-intervals
    measure(8, 0, 15, 1'b0, 0);

    // R8: duty change inside a period waits for the next period
    measure(8, -2, 1, 1'b1, 3);
    measure(8, 3, 1, 1'b0, 0);

    // R1: dropping enable while the lower switch is on
    measure(8, 0, 0, 1'b0, 0);
    wait_sync();
    chk(ls_n == 1'b0, "R1 low side on before disable", int'(ls_n), 0);
    enable = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(hs_n && ls_n && !sync && !phase, "R1 disabled outputs",
          {hs_n, ls_n, sync, phase}, 4'b1100);
    end
    enable = 1'b1;
    measure(6, 1, 1, 1'b0, 0);

    finish_run();
  end

endmodule